// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external request lines, numbered 0 to 27, and turns them into four grouped interrupt requests for an upstream interrupt controller. Each line first passes through a two-stage synchronizer. A per-line detector then applies the trigger type chosen for that line: low level, high level, falling edge, rising edge or either edge. Every detected event sets a sticky pending bit. Software clears a pending bit by writing a one to it.

A mask word decides which pending bits may reach the outputs. A line's request is live when its pending bit is set and its mask bit is clear. The four outputs each OR together the live requests of a fixed, unequal range of lines. Trigger types are packed so that each pair of neighbouring lines shares one 3-bit field. Lines 0 to 15 use one configuration word and lines 16 to 27 use a second one.

Top module: `ext_irq_grouper`

## Requirements
- R1: While reset is asserted, and immediately after it is released, both configuration words read 0, the pending word reads 0, the mask word reads 0x0FFFFFFF (every line blocked) and all four group outputs are low.
- R2: Configuration word 0 holds lines 0–15 and word 1 holds lines 16–27. Line i uses the 3-bit field at bit (k/2)*4, where k is i for word 0 and i-16 for word 1, so lines 2j and 2j+1 share a field. Bit 3 of each nibble always reads 0. Bits 31:24 of word 1 belong to no line: they read 0 and ignore writes.
- R3: Field value 000 selects low level and 001 selects high level. A level-mode line sets its pending bit on every cycle its synchronized input holds the active level.
- R4: Field value 01x selects falling edge, 10x rising edge and 11x both edges. An edge-mode line sets its pending bit only on the matching change of its synchronized input.
- R5: A change on an input line is seen by the detector after two synchronizer stages. A rising edge driven before clock edge 1 sets the pending bit at clock edge 3, and not earlier.
- R6: A detected event sets the pending bit whether or not the line is masked.
- R7: Writing the pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: A level-mode line whose input stays active cannot be cleared: the bit is already set again at the next read.
- R9: A mask bit of 1 blocks that line from the outputs and 0 lets it through. Mask bits 31:28 read 0 and ignore writes.
- R10: Output grpIrq[0] covers lines 0–3, grpIrq[1] lines 4–11, grpIrq[2] lines 12–19 and grpIrq[3] lines 20–27. Each is high exactly while some line in its range is pending and unmasked.
- R11: regSel selects the register: 00 configuration word 0, 01 configuration word 1, 10 mask, 11 pending. rdData shows the selected register combinationally. A write takes effect at the clock edge where wrEn is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 28 | Asynchronous external request lines |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register |
| grpIrq | output | 4 | Grouped interrupt requests |

## Verification
The assertions check the following on every cycle:
- a detected event is always present in the pending word on the next cycle;
- a pending bit drops only when it is written with a one;
- an edge-mode event happens only when the synchronized input has changed;
- no group output fires without a live request;
- the unused upper bits of the mask and of the second configuration word read 0.

Only the bench scenarios can show the points that depend on what software does and on input history:
- the exact three-cycle latency from input to pending bit;
- the field layout with its shared slots;
- the behaviour of each trigger encoding;
- the set-beats-clear case for an active level;
- which group each line lands in.

A reference model in the bench covers all of these through long random runs.

// File: rtl/eint_pkg.sv
package eint_pkg;

  localparam int NUM_LINES  = 28;
  localparam int REG_W      = 32;
  localparam int MODE_W     = 3;
  localparam int SLOT_W     = 4;
  localparam int LO_LINES   = 16;
  localparam int NUM_SLOTS  = NUM_LINES / 2;
  localparam int LO_SLOTS   = LO_LINES / 2;
  localparam int HI_SLOTS   = NUM_SLOTS - LO_SLOTS;
  localparam int NUM_GROUPS = 4;

  typedef enum logic [1:0] {
    SEL_CFG_LO = 2'b00,
    SEL_CFG_HI = 2'b01,
    SEL_MASK   = 2'b10,
    SEL_PEND   = 2'b11
  } regSel_e;

  typedef struct packed {
    logic                 cfgLoWr;
    logic                 cfgHiWr;
    logic                 maskWr;
    logic [NUM_LINES-1:0] pendClr;
    logic [REG_W-1:0]     data;
  } ctrlStrobe_t;

  function automatic int grpFirst(int g);
    case (g)
      0:       return 0;
      1:       return 4;
      2:       return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int grpLast(int g);
    case (g)
      0:       return 3;
      1:       return 11;
      2:       return 19;
      default: return NUM_LINES - 1;
    endcase
  endfunction

  function automatic logic [NUM_LINES-1:0] groupSpan(int g);
    logic [NUM_LINES-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (i >= grpFirst(g) && i <= grpLast(g)) v[i] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [REG_W-1:0] slotKeep(int n);
    logic [REG_W-1:0] w;
    w = '0;
    for (int s = 0; s < n; s++) w[s*SLOT_W +: MODE_W] = '1;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] lineKeep();
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_LINES; i++) w[i] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/eint_line_detect.sv
module eint_line_detect
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic [MODE_W-1:0] modeIn,
  output logic              evt
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   syncVal;
  logic                   prevVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= '0;
      prevVal <= 1'b0;
    end else begin
      chain   <= {chain[SYNC_STAGES-2:0], pinIn};
      prevVal <= syncVal;
    end
  end

  assign syncVal = chain[SYNC_STAGES-1];

  always_comb begin
    unique casez (modeIn)
      3'b000:  evt = ~syncVal;
      3'b001:  evt = syncVal;
      3'b01?:  evt = prevVal & ~syncVal;
      3'b10?:  evt = ~prevVal & syncVal;
      default: evt = prevVal ^ syncVal;
    endcase
  end

  // R4: an edge-mode event requires a change of the synchronized input
  a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rstN)
    (evt && (modeIn[2:1] != 2'b00)) |-> (syncVal != prevVal));

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
(
  input  logic             wrEn,
  input  regSel_e          regSel,
  input  logic [REG_W-1:0] wrData,
  output ctrlStrobe_t      str
);

  always_comb begin
    str         = '0;
    str.data    = wrData;
    if (wrEn) begin
      unique case (regSel)
        SEL_CFG_LO: str.cfgLoWr = 1'b1;
        SEL_CFG_HI: str.cfgHiWr = 1'b1;
        SEL_MASK:   str.maskWr  = 1'b1;
        default:    str.pendClr = wrData[NUM_LINES-1:0];
      endcase
    end
  end

endmodule

// File: rtl/eint_datapath.sv
module eint_datapath
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  ctrlStrobe_t           str,
  input  regSel_e               rdSel,
  output logic [REG_W-1:0]      rdData,
  output logic [NUM_GROUPS-1:0] grpIrq
);

  localparam logic [REG_W-1:0] LO_KEEP   = slotKeep(LO_SLOTS);
  localparam logic [REG_W-1:0] HI_KEEP   = slotKeep(HI_SLOTS);
  localparam logic [REG_W-1:0] LINE_KEEP = lineKeep();

  logic [REG_W-1:0]     cfgLoQ;
  logic [REG_W-1:0]     cfgHiQ;
  logic [REG_W-1:0]     maskQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] evtVec;
  logic [NUM_LINES-1:0] effReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= LINE_KEEP;
      pendQ  <= '0;
    end else begin
      if (str.cfgLoWr) cfgLoQ <= str.data & LO_KEEP;
      if (str.cfgHiWr) cfgHiQ <= str.data & HI_KEEP;
      if (str.maskWr)  maskQ  <= str.data & LINE_KEEP;
      pendQ <= (pendQ & ~str.pendClr) | evtVec;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int SLOT = (i < LO_LINES) ? (i / 2) : ((i - LO_LINES) / 2);
    logic [MODE_W-1:0] lineMode;
    if (i < LO_LINES) begin : g_lo
      assign lineMode = cfgLoQ[SLOT*SLOT_W +: MODE_W];
    end else begin : g_hi
      assign lineMode = cfgHiQ[SLOT*SLOT_W +: MODE_W];
    end
    eint_line_detect #(.SYNC_STAGES(SYNC_STAGES)) i_det (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (lineIn[i]),
      .modeIn (lineMode),
      .evt    (evtVec[i])
    );
  end

  assign effReq = pendQ & ~maskQ[NUM_LINES-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grpIrq[g] = |(effReq & groupSpan(g));
  end

  always_comb begin
    unique case (rdSel)
      SEL_CFG_LO: rdData = cfgLoQ;
      SEL_CFG_HI: rdData = cfgHiQ;
      SEL_MASK:   rdData = maskQ;
      default:    rdData = {{(REG_W-NUM_LINES){1'b0}}, pendQ};
    endcase
  end

  // R6: every detected event is visible in the pending word one cycle later
  a_r6_event_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(evtVec) & ~pendQ) == '0));

  // R7: a pending bit only drops when it was written with a one
  a_r7_no_spurious_drop: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(pendQ) & ~$past(str.pendClr)) & ~pendQ) == '0));

  // R7: a cleared bit with no simultaneous event reads zero afterwards
  a_r7_clear_takes_effect: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & $past(str.pendClr) & ~$past(evtVec)) == '0));

  // R10: no group output without a live request
  a_r10_group_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (effReq == '0) |-> (grpIrq == '0));

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
  import eint_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  logic                  wrEn,
  input  logic [1:0]            regSel,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      rdData,
  output logic [NUM_GROUPS-1:0] grpIrq
);

  ctrlStrobe_t strobe;
  regSel_e     selE;

  assign selE = regSel_e'(regSel);

  eint_ctrl i_ctrl (
    .wrEn   (wrEn),
    .regSel (selE),
    .wrData (wrData),
    .str    (strobe)
  );

  eint_datapath #(.SYNC_STAGES(2)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .str    (strobe),
    .rdSel  (selE),
    .rdData (rdData),
    .grpIrq (grpIrq)
  );

  // R9: unused mask bits never read back as set
  a_r9_mask_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'b10) |-> (rdData[REG_W-1:NUM_LINES] == '0));

  // R2: the field-less top of configuration word 1 reads zero
  a_r2_hi_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'b01) |-> (rdData[REG_W-1:HI_SLOTS*SLOT_W] == '0));

endmodule

// File: tb/test_ext_irq_grouper.sv
module test_ext_irq_grouper;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] lineIn = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = 2'b00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  grpIrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_grouper i_ext_irq_grouper (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .wrEn(wrEn),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .grpIrq(grpIrq)
  );

  // ---------------- reference model built from the requirements ----------
  logic [31:0] mLo, mHi, mMask;
  logic [27:0] mPend, mS1, mS2, mPrev, mEv;

  function automatic logic [27:0] modelEvents(logic [31:0] lo, logic [31:0] hi,
                                              logic [27:0] s, logic [27:0] p);
    logic [27:0] e;
    for (int i = 0; i < 28; i++) begin
      logic [2:0] m;
      m = (i < 16) ? lo[(i/2)*4 +: 3] : hi[((i-16)/2)*4 +: 3];
      if (m == 3'b000)           e[i] = ~s[i];
      else if (m == 3'b001)      e[i] = s[i];
      else if (m[2:1] == 2'b01)  e[i] = p[i] & ~s[i];
      else if (m[2:1] == 2'b10)  e[i] = ~p[i] & s[i];
      else                       e[i] = p[i] ^ s[i];
    end
    return e;
  endfunction

  function automatic logic [3:0] modelGroups(logic [27:0] pend, logic [31:0] msk);
    logic [27:0] eff;
    eff = pend & ~msk[27:0];
    return {|eff[27:20], |eff[19:12], |eff[11:4], |eff[3:0]};
  endfunction

  function automatic logic [31:0] modelRead(logic [1:0] sel);
    case (sel)
      2'b00:   return mLo;
      2'b01:   return mHi;
      2'b10:   return mMask;
      default: return {4'h0, mPend};
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLo <= '0; mHi <= '0; mMask <= 32'h0FFF_FFFF; mPend <= '0;
      mS1 <= '0; mS2 <= '0; mPrev <= '0;
    end else begin
      mEv = modelEvents(mLo, mHi, mS2, mPrev);
      mPend <= (mPend & ~((wrEn && regSel == 2'b11) ? wrData[27:0] : 28'h0)) | mEv;
      mS1 <= lineIn; mS2 <= mS1; mPrev <= mS2;
      if (wrEn && regSel == 2'b00) mLo   <= wrData & 32'h7777_7777;
      if (wrEn && regSel == 2'b01) mHi   <= wrData & 32'h0077_7777;
      if (wrEn && regSel == 2'b10) mMask <= wrData & 32'h0FFF_FFFF;
    end
  end

  // ---------------- check helpers ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(logic [1:0] sel, output logic [31:0] val);
    wrEn = 1'b0;
    regSel = sel;
    #1 val = rdData;
  endtask

  task automatic writeReg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // R10: group outputs follow the model on every cycle once running
  always @(negedge clk) begin
    if (rstN && !finished) begin
      #2 check("R10 group outputs", {28'h0, grpIrq}, {28'h0, modelGroups(mPend, mMask)});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));

    // R1: reset state
    waitCycles(3);
    readReg(2'b00, v); check("R1 cfg word 0 reset", v, 32'h0);
    readReg(2'b01, v); check("R1 cfg word 1 reset", v, 32'h0);
    readReg(2'b10, v); check("R1 mask reset", v, 32'h0FFF_FFFF);
    readReg(2'b11, v); check("R1 pending reset", v, 32'h0);
    check("R1 groups reset", {28'h0, grpIrq}, 32'h0);
    lineIn = '1;
    @(negedge clk) rstN = 1'b1;

    // R2 / R9: writable field masks
    writeReg(2'b00, 32'hFFFF_FFFF);
    readReg(2'b00, v); check("R2 cfg word 0 fields", v, 32'h7777_7777);
    writeReg(2'b01, 32'hFFFF_FFFF);
    readReg(2'b01, v); check("R2 cfg word 1 no field above line 27", v, 32'h0077_7777);
    writeReg(2'b10, 32'hFFFF_FFFF);
    readReg(2'b10, v); check("R9 mask upper bits", v, 32'h0FFF_FFFF);

    // all lines rising edge, inputs low, clear, unmask
    writeReg(2'b00, 32'h4444_4444);
    writeReg(2'b01, 32'h0044_4444);
    lineIn = '0;
    waitCycles(4);
    writeReg(2'b11, 32'hFFFF_FFFF);
    readReg(2'b11, v); check("R7 clear all", v, 32'h0);
    writeReg(2'b10, 32'h0);

    // R5: latency of exactly three edges
    lineIn[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    readReg(2'b11, v); check("R5 not yet pending after two edges", v, 32'h0);
    @(negedge clk);
    readReg(2'b11, v); check("R5 pending after three edges", v, 32'h20);
    check("R10 line 5 in group 1", {28'h0, grpIrq}, 32'h2);

    // R7: zero write keeps, one write clears
    writeReg(2'b11, 32'h0);
    readReg(2'b11, v); check("R7 write zero keeps bit", v, 32'h20);
    writeReg(2'b11, 32'h20);
    readReg(2'b11, v); check("R7 write one clears bit", v, 32'h0);

    // R6 / R9: masked line still latches but does not reach output
    writeReg(2'b10, 32'h2000);
    lineIn[13] = 1'b1;
    waitCycles(4);
    readReg(2'b11, v); check("R6 masked line latches", v, 32'h2000);
    check("R9 masked line blocked", {28'h0, grpIrq}, 32'h0);
    writeReg(2'b10, 32'h0);
    check("R10 line 13 in group 2", {28'h0, grpIrq}, 32'h4);
    writeReg(2'b11, 32'h2000);

    // R4: falling edge on line 20 (word 1 slot 2)
    writeReg(2'b01, 32'h0044_4244);
    lineIn[20] = 1'b1;
    waitCycles(4);
    readReg(2'b11, v); check("R4 falling mode ignores rise", v, 32'h0);
    lineIn[20] = 1'b0;
    waitCycles(4);
    readReg(2'b11, v); check("R4 falling mode sees fall", v, 32'h0010_0000);
    check("R10 line 20 in group 3", {28'h0, grpIrq}, 32'h8);
    writeReg(2'b11, 32'h0010_0000);

    // R4: both edges on line 21, same shared slot
    writeReg(2'b01, 32'h0044_4644);
    lineIn[21] = 1'b1;
    waitCycles(4);
    readReg(2'b11, v); check("R4 both mode sees rise", v, 32'h0020_0000);
    writeReg(2'b11, 32'h0020_0000);
    lineIn[21] = 1'b0;
    waitCycles(4);
    readReg(2'b11, v); check("R4 both mode sees fall", v, 32'h0020_0000);
    writeReg(2'b11, 32'h0020_0000);

    // R3 / R8: high level on line 0, set beats clear
    writeReg(2'b00, 32'h4444_4441);
    lineIn[0] = 1'b1;
    waitCycles(4);
    writeReg(2'b11, 32'h1);
    readReg(2'b11, v); check("R8 active level re-sets after clear", v, 32'h1);
    lineIn[0] = 1'b0;
    waitCycles(4);
    writeReg(2'b11, 32'h1);
    readReg(2'b11, v); check("R3 inactive high level stays clear", v, 32'h0);

    // R3 / R2: low level on shared slot 0 catches lines 0 and 1
    writeReg(2'b00, 32'h4444_4440);
    waitCycles(2);
    readReg(2'b11, v); check("R3 low level on shared slot", v, 32'h3);
    lineIn[1:0] = 2'b11;
    waitCycles(4);
    writeReg(2'b11, 32'h3);
    readReg(2'b11, v); check("R3 inactive low level stays clear", v, 32'h0);

    // R11: random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) lineIn = 28'($urandom);
      else lineIn[$urandom_range(0, 27)] = 1'($urandom);
      wrEn = ($urandom_range(0, 5) == 0);
      regSel = 2'($urandom);
      wrData = $urandom;
      if (regSel == 2'b11 && $urandom_range(0, 1) == 0) wrData = '1;
      #1 check("R11 read data", rdData, modelRead(regSel));
    end
    @(negedge clk) wrEn = 1'b0;
    waitCycles(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule